// File: doc/BRIEF.md
# Touch Controller Host Register Target

This block is the host-facing side of a capacitive touch controller. It is an I2C target that maps 128 byte locations. The host first sends a memory pointer. It then writes setup bytes or reads back the status bytes, the sensing core's data and the setup values. The setup locations 0x20 to 0x3F hold the key thresholds, the integrator and group codes, the guard select, the low-power mode and the max-on duration. All of these leave the block on one flat bus. Writing to location 0x3F also produces single-cycle soft-reset and calibration strobes.

An active-low open-drain change line tells the host when there is something to read. It pulls low when the detection-status byte or the key-status byte differs from what the host last read. A read of either status byte releases it. If the status returns to its old value before the host reads it, the line stays low until the next read of any location. After reset the line is held released for a programmable number of clock cycles and is then pulled low once.

The bus lines pass through synchronisers into a state machine with these states. S_IDLE waits for a START. S_RX_ADDR, S_RX_PTR and S_RX_DATA shift in the target address, the pointer byte and the write data. S_ACK_OUT drives an acknowledge. S_TX_DATA shifts out a read byte. S_TX_ACK_IN samples the host's acknowledge. S_IGNORE waits out a transfer that was not accepted.

The transitions are:
- A START from any state enters S_RX_ADDR, and a STOP from any state returns to S_IDLE.
- From S_RX_ADDR, a matching address goes through S_ACK_OUT to S_RX_PTR (write) or to S_TX_DATA (read). Any other address goes to S_IGNORE.
- An accepted pointer goes through S_ACK_OUT to S_RX_DATA. A rejected pointer goes to S_IGNORE.
- Each data byte goes through S_ACK_OUT and back to S_RX_DATA.
- After eight transmitted bits the machine enters S_TX_ACK_IN. A host ACK there returns to S_TX_DATA with the next byte, and a host NACK leads to S_IGNORE.

Top module: `touch_reg_target`

## Requirements
- R1: The target answers the 7-bit address 0x41 when addr_sel_i was low at reset and 0x46 when it was high. Any other address gets no acknowledge.
- R2: A pointer byte of 0x00 to 0x7F is acknowledged and loaded. A pointer byte with bit 7 set is not acknowledged and leaves the pointer unchanged.
- R3: Write data bytes are acknowledged and stored at consecutive locations, and the pointer advances by one per byte.
- R4: In a read, every transmitted byte advances the pointer. A host ACK gets the byte from the next location, and a host NACK ends the burst.
- R5: When a read transfer ends (STOP or repeated START), the pointer returns to the last pointer value the host wrote.
- R6: After reset the pointer is 0, and location 0x00 always reads 0x46.
- R7: Location 0x20+k is writable and appears on setup_o[8k+7:8k]. Writes below 0x20 are acknowledged and change nothing.
- R8: chg_pd_o rises when location 0x02 (detection status) or 0x03 (key status) differs from the value last read. Reading 0x02 or 0x03 releases it.
- R9: If the status returns to the last-read value before a read, chg_pd_o stays high until a read of any location.
- R10: Writing 0x3F with bit 7 set gives a one-cycle soft_reset_o. Writing it with any of bits 6:0 set gives a one-cycle calib_o.
- R11: chg_pd_o stays low for CHG_DELAY cycles after reset and is then set.
- R12: Reads of 0x01 and 0x04 to 0x1F return core_rd_data_i for the address on core_rd_addr_o.
- R13: A START in the middle of a byte restarts the address phase. After a STOP, sda_pd_o is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 1 | Address-select strap, sampled after reset |
| det_status_i | input | 8 | Live detection-status byte (location 0x02) |
| key_status_i | input | 8 | Live key-status byte (location 0x03) |
| core_rd_data_i | input | 8 | Read-only byte from the sensing core |
| core_rd_addr_o | output | 7 | Current memory pointer, selects the core byte |
| sda_pd_o | output | 1 | Pull-down enable for the data line |
| chg_pd_o | output | 1 | Pull-down enable for the change line |
| setup_o | output | 8*SETUP_COUNT | Setup bytes, location 0x20+k in byte k |
| soft_reset_o | output | 1 | Soft-reset request strobe |
| calib_o | output | 1 | Calibration request strobe |

## Verification
The hardest condition to reach is a status byte that changes and then returns to its last-read value with no read in between. In that case the change line must stay low even though the live bytes match the snapshot. The bench gets there by flipping key_status_i and restoring it a few cycles later, between transfers. It then releases the line with a read of a setup location. The other hard case is a repeated START placed three bits into a pointer byte. The bench's bit-level driver produces it, and a read that follows shows the pointer was left untouched.

// File: rtl/trt_pkg.sv
package trt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX_ADDR,
        S_RX_PTR,
        S_RX_DATA,
        S_ACK_OUT,
        S_TX_DATA,
        S_TX_ACK_IN,
        S_IGNORE
    } bus_state_e;

    localparam logic [7:0] ID_BYTE = 8'h46;
    localparam logic [6:0] LOC_ID  = 7'h00;
    localparam logic [6:0] LOC_DET = 7'h02;
    localparam logic [6:0] LOC_KEY = 7'h03;
    localparam logic [6:0] LOC_CMD = 7'h3F;
endpackage

// File: rtl/trt_bus_sync.sv
module trt_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] the previous one
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_s, scl_d, sda_s, sda_d;
    assign scl_s = scl_pipe[STAGES-1];
    assign scl_d = scl_pipe[STAGES];
    assign sda_s = sda_pipe[STAGES-1];
    assign sda_d = sda_pipe[STAGES];

    always_comb begin
        sda_o   = sda_s;
        rise_o  = scl_s && !scl_d;
        fall_o  = !scl_s && scl_d;
        start_o = scl_s && scl_d && sda_d && !sda_s;
        stop_o  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/trt_link_fsm.sv
module trt_link_fsm
    import trt_pkg::*;
#(
    parameter logic [6:0] ADDR_LO = 7'h41,
    parameter logic [6:0] ADDR_HI = 7'h46
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_i,
    input  logic       sda_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic [7:0] rd_data_i,
    output logic [6:0] ptr_o,
    output logic       rd_stb_o,
    output logic [6:0] rd_addr_o,
    output logic       wr_en_o,
    output logic [6:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       sda_pd_o
);
    bus_state_e state_q, after_q;
    logic       ack_q, host_ack_q, in_read_q, sel_q, strap_done_q;
    logic [7:0] rx_q, tx_q;
    logic [3:0] cnt_q;
    logic [6:0] ptr_q, base_q;
    logic [6:0] my_addr;

    assign my_addr = sel_q ? ADDR_HI : ADDR_LO;
    assign ptr_o   = ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            after_q      <= S_IDLE;
            ack_q        <= 1'b0;
            host_ack_q   <= 1'b0;
            in_read_q    <= 1'b0;
            sel_q        <= 1'b0;
            strap_done_q <= 1'b0;
            rx_q         <= '0;
            tx_q         <= '0;
            cnt_q        <= '0;
            ptr_q        <= '0;
            base_q       <= '0;
            rd_stb_o     <= 1'b0;
            rd_addr_o    <= '0;
            wr_en_o      <= 1'b0;
            wr_addr_o    <= '0;
            wr_data_o    <= '0;
        end else begin
            rd_stb_o <= 1'b0;
            wr_en_o  <= 1'b0;
            if (!strap_done_q) begin
                sel_q        <= strap_i;
                strap_done_q <= 1'b1;
            end
            if (start_i || stop_i) begin
                state_q <= start_i ? S_RX_ADDR : S_IDLE;
                cnt_q   <= '0;
                ack_q   <= 1'b0;
                if (in_read_q) begin
                    ptr_q     <= base_q;
                    in_read_q <= 1'b0;
                end
            end else begin
                unique case (state_q)
                    S_RX_ADDR, S_RX_PTR, S_RX_DATA: begin
                        if (rise_i) begin
                            rx_q  <= {rx_q[6:0], sda_i};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (fall_i && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (state_q == S_RX_ADDR) begin
                                if (rx_q[7:1] == my_addr) begin
                                    ack_q     <= 1'b1;
                                    state_q   <= S_ACK_OUT;
                                    after_q   <= rx_q[0] ? S_TX_DATA : S_RX_PTR;
                                    in_read_q <= rx_q[0];
                                end else begin
                                    state_q <= S_IGNORE;
                                end
                            end else if (state_q == S_RX_PTR) begin
                                if (!rx_q[7]) begin
                                    ptr_q   <= rx_q[6:0];
                                    base_q  <= rx_q[6:0];
                                    ack_q   <= 1'b1;
                                    state_q <= S_ACK_OUT;
                                    after_q <= S_RX_DATA;
                                end else begin
                                    state_q <= S_IGNORE;
                                end
                            end else begin
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr_q;
                                wr_data_o <= rx_q;
                                ptr_q     <= ptr_q + 7'd1;
                                ack_q     <= 1'b1;
                                state_q   <= S_ACK_OUT;
                                after_q   <= S_RX_DATA;
                            end
                        end
                    end
                    S_ACK_OUT: begin
                        if (fall_i) begin
                            ack_q   <= 1'b0;
                            state_q <= after_q;
                            cnt_q   <= '0;
                            if (after_q == S_TX_DATA) begin
                                tx_q      <= rd_data_i;
                                rd_stb_o  <= 1'b1;
                                rd_addr_o <= ptr_q;
                                ptr_q     <= ptr_q + 7'd1;
                            end
                        end
                    end
                    S_TX_DATA: begin
                        if (fall_i) begin
                            tx_q <= {tx_q[6:0], 1'b0};
                            if (cnt_q == 4'd7) begin
                                cnt_q   <= '0;
                                state_q <= S_TX_ACK_IN;
                            end else begin
                                cnt_q <= cnt_q + 4'd1;
                            end
                        end
                    end
                    S_TX_ACK_IN: begin
                        if (rise_i) begin
                            host_ack_q <= !sda_i;
                        end else if (fall_i) begin
                            if (host_ack_q) begin
                                tx_q      <= rd_data_i;
                                rd_stb_o  <= 1'b1;
                                rd_addr_o <= ptr_q;
                                ptr_q     <= ptr_q + 7'd1;
                                state_q   <= S_TX_DATA;
                            end else begin
                                state_q <= S_IGNORE;
                            end
                        end
                    end
                    S_IDLE, S_IGNORE: begin
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        sda_pd_o = ((state_q == S_ACK_OUT) && ack_q) ||
                   ((state_q == S_TX_DATA) && !tx_q[7]);
    end
endmodule

// File: rtl/trt_setup_regs.sv
module trt_setup_regs
    import trt_pkg::*;
#(
    parameter int SETUP_BASE  = 32,
    parameter int SETUP_COUNT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en_i,
    input  logic [6:0]               wr_addr_i,
    input  logic [7:0]               wr_data_i,
    input  logic [6:0]               rd_addr_i,
    input  logic [7:0]               det_i,
    input  logic [7:0]               key_i,
    input  logic [7:0]               core_i,
    output logic [7:0]               rd_data_o,
    output logic [8*SETUP_COUNT-1:0] setup_o,
    output logic                     soft_reset_o,
    output logic                     calib_o
);
    localparam int IDX_W = $clog2(SETUP_COUNT);

    function automatic logic in_win(input logic [6:0] a);
        return (int'(a) >= SETUP_BASE) && (int'(a) < SETUP_BASE + SETUP_COUNT);
    endfunction

    logic [IDX_W-1:0] wr_idx, rd_idx;
    assign wr_idx = IDX_W'(int'(wr_addr_i) - SETUP_BASE);
    assign rd_idx = IDX_W'(int'(rd_addr_i) - SETUP_BASE);

    for (genvar g = 0; g < SETUP_COUNT; g++) begin : g_reg
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en_i && in_win(wr_addr_i) && int'(wr_idx) == g) begin
                q <= wr_data_i;
            end
        end
        assign setup_o[8*g +: 8] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_reset_o <= 1'b0;
            calib_o      <= 1'b0;
        end else begin
            soft_reset_o <= wr_en_i && (wr_addr_i == LOC_CMD) && wr_data_i[7];
            calib_o      <= wr_en_i && (wr_addr_i == LOC_CMD) && (|wr_data_i[6:0]);
        end
    end

    always_comb begin
        if (rd_addr_i == LOC_ID)       rd_data_o = ID_BYTE;
        else if (rd_addr_i == LOC_DET) rd_data_o = det_i;
        else if (rd_addr_i == LOC_KEY) rd_data_o = key_i;
        else if (in_win(rd_addr_i))    rd_data_o = setup_o[8*rd_idx +: 8];
        else                           rd_data_o = core_i;
    end
endmodule

// File: rtl/trt_change_notify.sv
module trt_change_notify
    import trt_pkg::*;
#(
    parameter int CHG_DELAY = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] det_i,
    input  logic [7:0] key_i,
    input  logic       rd_stb_i,
    input  logic [6:0] rd_addr_i,
    output logic       chg_pd_o
);
    localparam int CW = $clog2(CHG_DELAY + 1);

    logic [CW-1:0] dly_q;
    logic [7:0]    snap_det_q, snap_key_q;
    logic          pending_q, ready, differs;

    assign ready   = (dly_q == CW'(CHG_DELAY));
    assign differs = (det_i != snap_det_q) || (key_i != snap_key_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q      <= '0;
            snap_det_q <= '0;
            snap_key_q <= '0;
            pending_q  <= 1'b0;
        end else if (!ready) begin
            dly_q <= dly_q + CW'(1);
            if (dly_q == CW'(CHG_DELAY - 1)) begin
                pending_q  <= 1'b1;
                snap_det_q <= det_i;
                snap_key_q <= key_i;
            end
        end else if (rd_stb_i) begin
            if (rd_addr_i == LOC_DET || rd_addr_i == LOC_KEY) begin
                snap_det_q <= det_i;
                snap_key_q <= key_i;
                pending_q  <= 1'b0;
            end else begin
                pending_q  <= differs;
            end
        end else if (differs) begin
            pending_q <= 1'b1;
        end
    end

    assign chg_pd_o = pending_q;
endmodule

// File: rtl/touch_reg_target.sv
module touch_reg_target #(
    parameter logic [6:0] ADDR_LO     = 7'h41,
    parameter logic [6:0] ADDR_HI     = 7'h46,
    parameter int         SYNC_STAGES = 2,
    parameter int         CHG_DELAY   = 1000000,
    parameter int         SETUP_BASE  = 32,
    parameter int         SETUP_COUNT = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_i,
    input  logic                     sda_i,
    input  logic                     addr_sel_i,
    input  logic [7:0]               det_status_i,
    input  logic [7:0]               key_status_i,
    input  logic [7:0]               core_rd_data_i,
    output logic [6:0]               core_rd_addr_o,
    output logic                     sda_pd_o,
    output logic                     chg_pd_o,
    output logic [8*SETUP_COUNT-1:0] setup_o,
    output logic                     soft_reset_o,
    output logic                     calib_o
);
    logic       sda_s, rise_ev, fall_ev, start_ev, stop_ev;
    logic       rd_stb, wr_en;
    logic [6:0] rd_addr, wr_addr, ptr;
    logic [7:0] wr_data, rd_data;

    trt_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .rise_o(rise_ev), .fall_o(fall_ev),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    trt_link_fsm #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_fsm (
        .clk(clk), .rst_n(rst_n), .strap_i(addr_sel_i), .sda_i(sda_s),
        .rise_i(rise_ev), .fall_i(fall_ev), .start_i(start_ev), .stop_i(stop_ev),
        .rd_data_i(rd_data), .ptr_o(ptr), .rd_stb_o(rd_stb), .rd_addr_o(rd_addr),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_pd_o(sda_pd_o)
    );

    trt_setup_regs #(.SETUP_BASE(SETUP_BASE), .SETUP_COUNT(SETUP_COUNT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(ptr), .det_i(det_status_i),
        .key_i(key_status_i), .core_i(core_rd_data_i), .rd_data_o(rd_data),
        .setup_o(setup_o), .soft_reset_o(soft_reset_o), .calib_o(calib_o)
    );

    trt_change_notify #(.CHG_DELAY(CHG_DELAY)) u_chg (
        .clk(clk), .rst_n(rst_n), .det_i(det_status_i), .key_i(key_status_i),
        .rd_stb_i(rd_stb), .rd_addr_i(rd_addr), .chg_pd_o(chg_pd_o)
    );

    assign core_rd_addr_o = ptr;
endmodule

// File: rtl/trt_checker.sv
module trt_checker #(
    parameter int CHG_DELAY  = 1000000,
    parameter int SETUP_BASE = 32,
    parameter int SETUP_W    = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sda_pd_o,
    input logic               chg_pd_o,
    input logic               stop_ev,
    input logic               wr_en,
    input logic [6:0]         wr_addr,
    input logic [7:0]         wr_data,
    input logic [SETUP_W-1:0] setup_o,
    input logic               soft_reset_o,
    input logic               calib_o
);
    logic [31:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       age_q <= '0;
        else if (age_q < 32'(CHG_DELAY))  age_q <= age_q + 32'd1;
    end

    assert_chg_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < 32'(CHG_DELAY)) |-> !chg_pd_o);

    assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) < SETUP_BASE) |=> $stable(setup_o));

    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h3F && wr_data[7]) |=> soft_reset_o);

    assert_calib_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 7'h3F && (|wr_data[6:0])) |=> calib_o);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset_o || calib_o) |=> !(soft_reset_o || calib_o));

    assert_stop_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_pd_o);
endmodule

bind touch_reg_target trt_checker #(
    .CHG_DELAY(CHG_DELAY), .SETUP_BASE(SETUP_BASE), .SETUP_W(8*SETUP_COUNT)
) u_checker (
    .clk(clk), .rst_n(rst_n), .sda_pd_o(sda_pd_o), .chg_pd_o(chg_pd_o),
    .stop_ev(stop_ev), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .setup_o(setup_o), .soft_reset_o(soft_reset_o), .calib_o(calib_o)
);

// File: tb/test_touch_reg_target.sv
module test_touch_reg_target;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int DLY        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_host = 1'b1;
    logic        strap = 1'b0;
    logic [7:0]  det = 8'h00;
    logic [7:0]  key = 8'h00;
    logic [7:0]  core_data;
    logic [6:0]  core_addr;
    logic        sda_pd, chg_pd, sr_o, cal_o;
    logic [255:0] setup;
    wire         sda_line = sda_host & ~sda_pd;

    int vectors = 0;
    int errors  = 0;
    int sr_cnt  = 0;
    int cal_cnt = 0;

    logic [6:0] dev;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    logic [7:0] mdl  [32];
    bit         a_dev, a_ptr, a_dat;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] core_fn(input logic [6:0] a);
        return {a, 1'b1} ^ 8'h5C;
    endfunction

    always_comb core_data = core_fn(core_addr);

    always @(posedge clk) begin
        if (sr_o)  sr_cnt++;
        if (cal_o) cal_cnt++;
    end

    touch_reg_target #(.CHG_DELAY(DLY)) i_touch_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_sel_i(strap), .det_status_i(det), .key_status_i(key),
        .core_rd_data_i(core_data), .core_rd_addr_o(core_addr),
        .sda_pd_o(sda_pd), .chg_pd_o(chg_pd), .setup_o(setup),
        .soft_reset_o(sr_o), .calib_o(cal_o)
    );

    function automatic logic [7:0] exp_read(input logic [6:0] a);
        if (a == 7'h00) return 8'h46;
        if (a == 7'h02) return det;
        if (a == 7'h03) return key;
        if (a >= 7'h20 && a <= 7'h3F) return mdl[a - 7'h20];
        return core_fn(a);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_host = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_host = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        sda_host = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_host = 1'b1; tick(Q);
    endtask

    task automatic wbits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            tick(Q/2); sda_host = v[7-i]; tick(Q/2);
            scl = 1'b1; tick(Q); scl = 1'b0;
        end
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        wbits(v, 8);
        tick(Q/2); sda_host = 1'b1; tick(Q/2);
        scl = 1'b1; tick(Q/2); ack = !sda_line; tick(Q/2); scl = 1'b0;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] v);
        sda_host = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q); scl = 1'b1; tick(Q/2); v[7-i] = sda_line; tick(Q/2); scl = 1'b0;
        end
        tick(Q/2); sda_host = !give_ack; tick(Q/2);
        scl = 1'b1; tick(Q); scl = 1'b0; tick(Q/2); sda_host = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bstart(); wbyte({dev, 1'b0}, a_dev); wbyte(p, a_ptr); bstop();
    endtask

    task automatic wr_burst(input logic [6:0] p, input int n);
        bstart(); wbyte({dev, 1'b0}, a_dev); wbyte({1'b0, p}, a_ptr);
        for (int i = 0; i < n; i++) begin
            logic [6:0] a;
            wbyte(wbuf[i], a_dat);
            check("R3 data ack", int'(a_dat), 1);
            a = p + 7'(i);
            if (a >= 7'h20) mdl[a - 7'h20] = wbuf[i];
        end
        bstop();
    endtask

    task automatic rd_burst(input int n);
        bstart(); wbyte({dev, 1'b1}, a_dev);
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
        bstop();
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        vectors++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        dev = 7'h41;
        tick(5); rst_n = 1'b1; tick(10);
        check("R11 change quiet after reset", int'(chg_pd), 0);
        check("R13 sda released at reset", int'(sda_pd), 0);
        tick(DLY);
        check("R11 change set after delay", int'(chg_pd), 1);

        // R6: pointer starts at 0 and location 0 holds the ID
        rd_burst(1);
        check("R1 strap-low address acked", int'(a_dev), 1);
        check("R6 id byte", int'(rbuf[0]), 8'h46);
        check("R11 any read releases power-up flag", int'(chg_pd), 0);

        // R8: status change pulls, status read releases
        det = 8'h01; tick(5);
        check("R8 change on status", int'(chg_pd), 1);
        set_ptr(8'h02); rd_burst(2);
        check("R4 burst byte 0x02", int'(rbuf[0]), 8'h01);
        check("R4 burst byte 0x03", int'(rbuf[1]), 8'h00);
        check("R8 release after status read", int'(chg_pd), 0);
        rd_burst(1);
        check("R5 pointer snapped back", int'(rbuf[0]), 8'h01);

        // R9: change then revert before any read
        key = 8'h10; tick(4); key = 8'h00; tick(4);
        check("R9 change held after revert", int'(chg_pd), 1);
        set_ptr(8'h21);
        check("R9 pointer writes keep flag", int'(chg_pd), 1);
        rd_burst(1);
        check("R9 any read releases", int'(chg_pd), 0);

        // R2: out-of-range pointer
        set_ptr(8'h90);
        check("R2 pointer nack", int'(a_ptr), 0);
        rd_burst(1);
        check("R2 pointer unchanged", int'(rbuf[0]), int'(mdl[1]));

        // R1: foreign address
        dev = 7'h46; set_ptr(8'h05);
        check("R1 foreign address nack", int'(a_dev), 0);
        dev = 7'h41;

        // R12: core data window
        set_ptr(8'h06); rd_burst(3);
        for (int i = 0; i < 3; i++)
            check("R12 core byte", int'(rbuf[i]), int'(core_fn(7'(6 + i))));

        // R7: writes into read-only space
        wbuf[0] = 8'hFF; wr_burst(7'h05, 1);
        set_ptr(8'h05); rd_burst(1);
        check("R7 read-only unchanged", int'(rbuf[0]), int'(core_fn(7'h05)));
        wbuf[0] = 8'h00; wr_burst(7'h00, 1);
        set_ptr(8'h00); rd_burst(1);
        check("R7 id unchanged", int'(rbuf[0]), 8'h46);

        // R3 R4 R5 R7: random bursts in setup space and read-only space
        for (int it = 0; it < 24; it++) begin
            logic [6:0] p;
            int n;
            p = 7'h20 + 7'($urandom % 28);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_burst(p, n);
            check("R2 pointer ack", int'(a_ptr), 1);
            for (int i = 0; i < n; i++)
                check("R7 setup field", int'(setup[8*(int'(p) - 32 + i) +: 8]), int'(wbuf[i]));
            set_ptr({1'b0, p}); rd_burst(n);
            for (int i = 0; i < n; i++)
                check("R4 read burst", int'(rbuf[i]), int'(exp_read(p + 7'(i))));
            rd_burst(1);
            check("R5 repeat read", int'(rbuf[0]), int'(exp_read(p)));
            p = 7'($urandom % 32);
            set_ptr({1'b0, p}); rd_burst(2);
            check("R12 low space read", int'(rbuf[0]), int'(exp_read(p)));
            check("R12 low space next", int'(rbuf[1]), int'(exp_read(p + 7'd1)));
        end

        // R10: command strobes
        begin
            int s0, c0;
            s0 = sr_cnt; c0 = cal_cnt;
            wbuf[0] = 8'h80; wr_burst(7'h3F, 1); tick(4);
            check("R10 soft reset pulse", sr_cnt - s0, 1);
            check("R10 no calib on bit7 only", cal_cnt - c0, 0);
            s0 = sr_cnt; c0 = cal_cnt;
            wbuf[0] = 8'h03; wr_burst(7'h3F, 1); tick(4);
            check("R10 calib pulse", cal_cnt - c0, 1);
            check("R10 no soft reset", sr_cnt - s0, 0);
        end

        // R13: repeated START three bits into the pointer byte
        set_ptr(8'h25);
        bstart(); wbyte({dev, 1'b0}, a_dev); wbits(8'h55, 3);
        bstart(); wbyte({dev, 1'b1}, a_dev);
        check("R13 restart address acked", int'(a_dev), 1);
        rbyte(1'b0, rbuf[0]); bstop(); tick(4);
        check("R13 pointer untouched", int'(rbuf[0]), int'(mdl[5]));
        check("R13 sda released after stop", int'(sda_pd), 0);

        // R1: strap high selects the other address
        rst_n = 1'b0; strap = 1'b1; tick(3); rst_n = 1'b1; tick(5);
        dev = 7'h46; set_ptr(8'h00);
        check("R1 strap-high address acked", int'(a_dev), 1);
        dev = 7'h41; set_ptr(8'h00);
        check("R1 old address now nacked", int'(a_dev), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule